// File: doc/BRIEF.md
# Grayscale Display Timer

This block times the display period of a bank of LED sink channels driven by conventional pulse-width modulation. A grayscale counter of `GS_W` bits advances on every grayscale clock event (`gs_tick`, a one-cycle strobe in the system clock domain). Each channel is held on from the first event of a period for as many events as its active grayscale value, so the on-time equals the value times the grayscale clock period.

A grayscale latch strobe (`gs_lat`) makes new pending grayscale and dot-correction words active. The strobe works under three mode inputs. The timing-reset mode restarts the counter and blanks the outputs at the strobe. The repeat mode chooses between continuous periods and a single period per strobe. The deferred mode holds the new words back until the 2^GS_W-th event after the strobe, then copies both words together.

The block also produces a one-cycle end-of-period pulse, and a status strobe at a fixed event of each period. With that strobe it captures fault flags, masked by the channels that are on at that moment.

Top module: `gs_display_timer`

## Requirements
- R1: After reset every channel is off, `disp_count` is 0, both active words are 0, `upd_pending`, `period_end` and `status_strobe` are 0, and `gs_tick` events do not move the counter until the first `gs_lat`.
- R2: While a period runs, each `gs_tick` increments `disp_count` by one, visible one clock later, and the counter wraps to 0 on the 2^GS_W-th event of the period.
- R3: Channel i takes its grayscale value from `act_gs[i*GS_W +: GS_W]`. After the p-th event of a period it is on exactly when 1 <= p <= value, so a value of 0 never lights the channel, and every channel is off after the wrap event. The output is registered and follows the event by one clock.
- R4: A `gs_lat` with `tmr_rst_en`=1 sets `disp_count` to 0 and turns every channel off one clock later. A `gs_tick` in the same cycle is ignored. The next event starts a new period.
- R5: A `gs_lat` with `tmr_rst_en`=0 leaves `disp_count` unchanged. The channels are then re-evaluated against the new active values at the current count.
- R6: With `rpt_en`=1, periods follow one another while events arrive. With `rpt_en`=0, the block goes idle after the wrap event: the counter stays at 0 and the channels stay off until the next `gs_lat`, which starts one more period from count 0.
- R7: `period_end` is high for exactly one clock, the clock after the wrap event, and `disp_count` is 0 while it is high.
- R8: With `defer_en`=0, a `gs_lat` copies `pend_gs` into `act_gs` and `pend_dc` into `act_dc` (channel i in bits `[i*DC_W +: DC_W]`), visible one clock later.
- R9: With `defer_en`=1, a `gs_lat` leaves both active words unchanged and raises `upd_pending`. On the 2^GS_W-th `gs_tick` after that strobe, counted independently of the display counter's phase, both words are copied together and `upd_pending` clears. A new strobe restarts the count.
- R10: On the `STAT_TICK`-th event of a period, `status_strobe` pulses for one clock. In the same clock, `det_status` takes `det_raw` ANDed with the channels that are on after that event. `det_status` holds its value between strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gs_tick | input | 1 | One-cycle strobe per grayscale clock rising edge |
| gs_lat | input | 1 | One-cycle grayscale latch strobe |
| tmr_rst_en | input | 1 | Restart the counter and blank the outputs at a latch strobe |
| rpt_en | input | 1 | Repeat periods continuously |
| defer_en | input | 1 | Defer the active-word copy to the 2^GS_W-th event after the strobe |
| pend_gs | input | NUM_CH*GS_W | Pending grayscale values |
| pend_dc | input | NUM_CH*DC_W | Pending dot-correction values |
| det_raw | input | NUM_CH | Raw per-channel fault flags |
| ch_on | output | NUM_CH | Per-channel on/off drive |
| act_gs | output | NUM_CH*GS_W | Active grayscale values |
| act_dc | output | NUM_CH*DC_W | Active dot-correction values |
| disp_count | output | GS_W | Grayscale counter |
| period_end | output | 1 | One-cycle end-of-period pulse |
| status_strobe | output | 1 | One-cycle fault capture strobe |
| det_status | output | NUM_CH | Captured fault flags |
| upd_pending | output | 1 | A deferred copy is waiting |

## Verification
The bench builds the block with four channels, a 6-bit counter and the status event at 33. A full period is therefore 64 events. Wrap, one-shot idling, repetition into a second period and the deferred copy can all be reached within a few hundred clocks. With this counter, the status event sits just past the midpoint of the period, so grayscale values of 32 and 33 fall on either side of the capture mask. Starting the deferred copy at a counter phase of 5 shows that the copy follows the strobe and not the wrap.

// File: rtl/gsd_pkg.sv
`timescale 1ns/1ps
package gsd_pkg;

    // source of the next active grayscale / dot-correction words
    typedef enum logic [1:0] {
        UPD_HOLD  = 2'd0,
        UPD_NOW   = 2'd1,
        UPD_DEFER = 2'd2
    } upd_src_e;

    function automatic upd_src_e pick_src(input logic lat,
                                          input logic defer_en,
                                          input logic copy);
        if (lat && !defer_en) return UPD_NOW;
        if (copy)             return UPD_DEFER;
        return UPD_HOLD;
    endfunction

endpackage

// File: rtl/gsd_period_ctl.sv
`timescale 1ns/1ps
module gsd_period_ctl #(
    parameter int GS_W      = 16,
    parameter int STAT_TICK = 33
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic            lat,
    input  logic            tmr_rst_en,
    input  logic            rpt_en,
    output logic [GS_W-1:0] cnt_q,
    output logic [GS_W-1:0] cnt_nx,
    output logic            stat_nx,
    output logic            period_end_q
);
    localparam logic [GS_W-1:0] CNT_TOP  = '1;
    localparam logic [GS_W-1:0] STAT_VAL = GS_W'(STAT_TICK);

    typedef struct packed {
        logic [GS_W-1:0] cnt;
        logic            run;
        logic            end_p;
    } per_st_t;

    per_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.end_p = 1'b0;
        stat_nx    = 1'b0;
        if (lat && tmr_rst_en) begin
            // restart wins over a coincident event
            st_d.cnt = '0;
            st_d.run = 1'b1;
        end else begin
            if (lat) st_d.run = 1'b1;
            if (tick && st_q.run) begin
                st_d.cnt = st_q.cnt + 1'b1;
                if (st_q.cnt == CNT_TOP) begin
                    st_d.end_p = 1'b1;
                    if (!rpt_en && !lat) st_d.run = 1'b0;
                end
                if (st_d.cnt == STAT_VAL) stat_nx = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_q        = st_q.cnt;
    assign cnt_nx       = st_d.cnt;
    assign period_end_q = st_q.end_p;

endmodule

// File: rtl/gsd_defer_ctl.sv
`timescale 1ns/1ps
module gsd_defer_ctl #(
    parameter int GS_W = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic lat,
    input  logic defer_en,
    output logic pending_q,
    output logic copy_nx
);
    localparam logic [GS_W-1:0] DCNT_TOP = '1;

    typedef struct packed {
        logic [GS_W-1:0] dcnt;
        logic            pending;
    } dfr_st_t;

    dfr_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        copy_nx = 1'b0;
        if (lat) begin
            st_d.dcnt    = '0;
            st_d.pending = defer_en;
        end else if (tick && st_q.pending) begin
            if (st_q.dcnt == DCNT_TOP) begin
                copy_nx      = 1'b1;
                st_d.pending = 1'b0;
                st_d.dcnt    = '0;
            end else begin
                st_d.dcnt = st_q.dcnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pending_q = st_q.pending;

endmodule

// File: rtl/gsd_lane.sv
`timescale 1ns/1ps
module gsd_lane #(
    parameter int GS_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [GS_W-1:0] gs_nx,
    input  logic [GS_W-1:0] cnt_nx,
    input  logic            stat_nx,
    input  logic            fault_raw,
    output logic            on_q,
    output logic            flt_q
);
    typedef struct packed {
        logic on;
        logic flt;
    } lane_st_t;

    lane_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.on = (cnt_nx != '0) && (cnt_nx <= gs_nx);
        if (stat_nx) st_d.flt = fault_raw & st_d.on;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign on_q  = st_q.on;
    assign flt_q = st_q.flt;

endmodule

// File: rtl/gs_display_timer.sv
`timescale 1ns/1ps
module gs_display_timer
    import gsd_pkg::*;
#(
    parameter int NUM_CH    = 48,
    parameter int GS_W      = 16,
    parameter int DC_W      = 7,
    parameter int STAT_TICK = 33
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   gs_tick,
    input  logic                   gs_lat,
    input  logic                   tmr_rst_en,
    input  logic                   rpt_en,
    input  logic                   defer_en,
    input  logic [NUM_CH*GS_W-1:0] pend_gs,
    input  logic [NUM_CH*DC_W-1:0] pend_dc,
    input  logic [NUM_CH-1:0]      det_raw,
    output logic [NUM_CH-1:0]      ch_on,
    output logic [NUM_CH*GS_W-1:0] act_gs,
    output logic [NUM_CH*DC_W-1:0] act_dc,
    output logic [GS_W-1:0]        disp_count,
    output logic                   period_end,
    output logic                   status_strobe,
    output logic [NUM_CH-1:0]      det_status,
    output logic                   upd_pending
);
    localparam int GS_BITS = NUM_CH * GS_W;
    localparam int DC_BITS = NUM_CH * DC_W;

    typedef struct packed {
        logic [GS_BITS-1:0] gs;
        logic [DC_BITS-1:0] dc;
        logic               strobe;
    } top_st_t;

    top_st_t         st_d, st_q;
    logic [GS_W-1:0] cnt_q, cnt_nx;
    logic            stat_nx;
    logic            copy_nx;
    upd_src_e        src;

    gsd_period_ctl #(.GS_W(GS_W), .STAT_TICK(STAT_TICK)) u_period (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick         (gs_tick),
        .lat          (gs_lat),
        .tmr_rst_en   (tmr_rst_en),
        .rpt_en       (rpt_en),
        .cnt_q        (cnt_q),
        .cnt_nx       (cnt_nx),
        .stat_nx      (stat_nx),
        .period_end_q (period_end)
    );

    gsd_defer_ctl #(.GS_W(GS_W)) u_defer (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (gs_tick),
        .lat       (gs_lat),
        .defer_en  (defer_en),
        .pending_q (upd_pending),
        .copy_nx   (copy_nx)
    );

    always_comb begin
        st_d        = st_q;
        st_d.strobe = stat_nx;
        src         = pick_src(gs_lat, defer_en, copy_nx);
        unique case (src)
            UPD_NOW, UPD_DEFER: begin
                st_d.gs = pend_gs;
                st_d.dc = pend_dc;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar i = 0; i < NUM_CH; i++) begin : g_lane
        gsd_lane #(.GS_W(GS_W)) u_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .gs_nx     (st_d.gs[i*GS_W +: GS_W]),
            .cnt_nx    (cnt_nx),
            .stat_nx   (stat_nx),
            .fault_raw (det_raw[i]),
            .on_q      (ch_on[i]),
            .flt_q     (det_status[i])
        );
    end

    assign act_gs        = st_q.gs;
    assign act_dc        = st_q.dc;
    assign disp_count    = cnt_q;
    assign status_strobe = st_q.strobe;

endmodule

// File: rtl/gsd_chk.sv
`timescale 1ns/1ps
module gsd_chk #(
    parameter int NUM_CH    = 48,
    parameter int GS_W      = 16,
    parameter int STAT_TICK = 33
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   gs_lat,
    input logic                   tmr_rst_en,
    input logic [NUM_CH*GS_W-1:0] pend_gs,
    input logic [NUM_CH-1:0]      ch_on,
    input logic [NUM_CH*GS_W-1:0] act_gs,
    input logic [GS_W-1:0]        disp_count,
    input logic                   period_end,
    input logic                   status_strobe,
    input logic [NUM_CH-1:0]      det_status,
    input logic                   upd_pending
);
    // R3
    lit_needs_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_on != '0) |-> (disp_count != '0));

    // R4
    restart_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gs_lat && tmr_rst_en) |=> (disp_count == '0 && ch_on == '0));

    // R7
    end_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        period_end |-> (disp_count == '0));

    // R7
    end_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        period_end |=> !period_end);

    // R9
    defer_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(upd_pending) && !$past(gs_lat)) |-> (act_gs == $past(pend_gs)));

    // R10
    status_point_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status_strobe |-> (disp_count == GS_W'(STAT_TICK)));

    // R10
    status_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status_strobe |-> ((det_status & ~ch_on) == '0));

endmodule

bind gs_display_timer gsd_chk #(
    .NUM_CH    (NUM_CH),
    .GS_W      (GS_W),
    .STAT_TICK (STAT_TICK)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .gs_lat        (gs_lat),
    .tmr_rst_en    (tmr_rst_en),
    .pend_gs       (pend_gs),
    .ch_on         (ch_on),
    .act_gs        (act_gs),
    .disp_count    (disp_count),
    .period_end    (period_end),
    .status_strobe (status_strobe),
    .det_status    (det_status),
    .upd_pending   (upd_pending)
);

// File: tb/tb_gs_display_timer.sv
`timescale 1ns/1ps
module tb_gs_display_timer;
    localparam int NUM_CH    = 4;
    localparam int GS_W      = 6;
    localparam int DC_W      = 7;
    localparam int STAT_TICK = 33;

    logic                   clk = 1'b0;
    logic                   rst_n;
    logic                   gs_tick, gs_lat, tmr_rst_en, rpt_en, defer_en;
    logic [NUM_CH*GS_W-1:0] pend_gs;
    logic [NUM_CH*DC_W-1:0] pend_dc;
    logic [NUM_CH-1:0]      det_raw;
    logic [NUM_CH-1:0]      ch_on;
    logic [NUM_CH*GS_W-1:0] act_gs;
    logic [NUM_CH*DC_W-1:0] act_dc;
    logic [GS_W-1:0]        disp_count;
    logic                   period_end, status_strobe, upd_pending;
    logic [NUM_CH-1:0]      det_status;

    int n_chk  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    gs_display_timer #(
        .NUM_CH(NUM_CH), .GS_W(GS_W), .DC_W(DC_W), .STAT_TICK(STAT_TICK)
    ) dut (
        .clk(clk), .rst_n(rst_n), .gs_tick(gs_tick), .gs_lat(gs_lat),
        .tmr_rst_en(tmr_rst_en), .rpt_en(rpt_en), .defer_en(defer_en),
        .pend_gs(pend_gs), .pend_dc(pend_dc), .det_raw(det_raw),
        .ch_on(ch_on), .act_gs(act_gs), .act_dc(act_dc),
        .disp_count(disp_count), .period_end(period_end),
        .status_strobe(status_strobe), .det_status(det_status),
        .upd_pending(upd_pending)
    );

    // row: {gs ch3..ch0 (24b), ticks after restart (8b), expected ch_on (4b)}
    localparam int NROW = 11;
    localparam logic [35:0] VEC [NROW] = '{
        {6'd63, 6'd2,  6'd1,  6'd0,  8'd1,  4'b1110},
        {6'd63, 6'd2,  6'd1,  6'd0,  8'd2,  4'b1100},
        {6'd63, 6'd2,  6'd1,  6'd0,  8'd3,  4'b1000},
        {6'd63, 6'd2,  6'd1,  6'd0,  8'd63, 4'b1000},
        {6'd63, 6'd2,  6'd1,  6'd0,  8'd64, 4'b0000},
        {6'd40, 6'd30, 6'd20, 6'd10, 8'd0,  4'b0000},
        {6'd40, 6'd30, 6'd20, 6'd10, 8'd20, 4'b1110},
        {6'd40, 6'd30, 6'd20, 6'd10, 8'd21, 4'b1100},
        {6'd40, 6'd30, 6'd20, 6'd10, 8'd40, 4'b1000},
        {6'd40, 6'd30, 6'd20, 6'd10, 8'd41, 4'b0000},
        {6'd40, 6'd30, 6'd20, 6'd10, 8'd65, 4'b1111}
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        for (int k = 0; k < n; k++) begin
            gs_tick = 1'b1;
            @(posedge clk); #1;
        end
        gs_tick = 1'b0;
    endtask

    task automatic idle();
        @(posedge clk); #1;
    endtask

    task automatic latch(input logic tmr, input logic dfr);
        tmr_rst_en = tmr;
        defer_en   = dfr;
        gs_lat     = 1'b1;
        @(posedge clk); #1;
        gs_lat     = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; gs_tick = 1'b0; gs_lat = 1'b0; tmr_rst_en = 1'b0;
        rpt_en = 1'b0; defer_en = 1'b0; pend_gs = '0; pend_dc = '0; det_raw = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        chk("R1 ch_on", 64'(ch_on), 0);
        chk("R1 count", 64'(disp_count), 0);
        chk("R1 act_gs", 64'(act_gs), 0);
        chk("R1 act_dc", 64'(act_dc), 0);
        chk("R1 flags", 64'({upd_pending, period_end, status_strobe}), 0);
        ticks(3);
        chk("R1 ticks before latch count", 64'(disp_count), 0);
        chk("R1 ticks before latch ch_on", 64'(ch_on), 0);

        // R2 / R3 table walk, timing reset each row, repeat on
        rpt_en = 1'b1;
        for (int r = 0; r < NROW; r++) begin
            pend_gs = VEC[r][35:12];
            latch(1'b1, 1'b0);
            ticks(int'(VEC[r][11:4]));
            chk($sformatf("R3 row %0d ch_on", r), 64'(ch_on), 64'(VEC[r][3:0]));
            chk($sformatf("R2 row %0d count", r), 64'(disp_count), 64'(VEC[r][11:4] % 64));
        end

        // R8 immediate copy of both words
        pend_dc = 28'h1234567;
        latch(1'b1, 1'b0);
        chk("R8 act_gs", 64'(act_gs), 64'({6'd40, 6'd30, 6'd20, 6'd10}));
        chk("R8 act_dc", 64'(act_dc), 64'h1234567);

        // R5 latch without timing reset
        ticks(15);
        chk("R5 pre count", 64'(disp_count), 15);
        chk("R5 pre ch_on", 64'(ch_on), 64'(4'b1110));
        pend_gs = {6'd0, 6'd16, 6'd5, 6'd63};
        latch(1'b0, 1'b0);
        chk("R5 count kept", 64'(disp_count), 15);
        chk("R5 new values", 64'(ch_on), 64'(4'b0101));

        // R4 timing reset
        ticks(2);
        chk("R4 pre ch_on", 64'(ch_on), 64'(4'b0001));
        latch(1'b1, 1'b0);
        chk("R4 count zero", 64'(disp_count), 0);
        chk("R4 blank", 64'(ch_on), 0);
        gs_tick = 1'b1;
        latch(1'b1, 1'b0);
        gs_tick = 1'b0;
        chk("R4 tick ignored with latch", 64'(disp_count), 0);
        ticks(1);
        chk("R4 restart count", 64'(disp_count), 1);
        chk("R4 restart ch_on", 64'(ch_on), 64'(4'b0111));

        // R6 / R7 one-shot period
        rpt_en  = 1'b0;
        pend_gs = {6'd63, 6'd63, 6'd63, 6'd63};
        latch(1'b1, 1'b0);
        ticks(63);
        chk("R6 last event on", 64'(ch_on), 64'(4'b1111));
        chk("R7 no early end", 64'(period_end), 0);
        ticks(1);
        chk("R7 end pulse", 64'(period_end), 1);
        chk("R7 count at end", 64'(disp_count), 0);
        chk("R3 off after wrap", 64'(ch_on), 0);
        idle();
        chk("R7 pulse one clock", 64'(period_end), 0);
        ticks(5);
        chk("R6 idle count", 64'(disp_count), 0);
        chk("R6 idle ch_on", 64'(ch_on), 0);
        latch(1'b0, 1'b0);
        ticks(1);
        chk("R6 relatch count", 64'(disp_count), 1);
        chk("R6 relatch ch_on", 64'(ch_on), 64'(4'b1111));

        // R9 deferred copy, started at counter phase 5
        rpt_en = 1'b1;
        ticks(4);
        chk("R9 phase", 64'(disp_count), 5);
        pend_gs = {6'd1, 6'd2, 6'd3, 6'd4};
        pend_dc = 28'hABCDEF0;
        latch(1'b0, 1'b1);
        chk("R9 pending set", 64'(upd_pending), 1);
        chk("R9 gs held", 64'(act_gs), 64'hFFFFFF);
        ticks(63);
        chk("R9 gs held late", 64'(act_gs), 64'hFFFFFF);
        chk("R9 dc held late", 64'(act_dc), 64'h1234567);
        chk("R9 still pending", 64'(upd_pending), 1);
        chk("R9 count wrapped", 64'(disp_count), 4);
        ticks(1);
        chk("R9 gs copied", 64'(act_gs), 64'({6'd1, 6'd2, 6'd3, 6'd4}));
        chk("R9 dc copied", 64'(act_dc), 64'hABCDEF0);
        chk("R9 pending clear", 64'(upd_pending), 0);
        chk("R9 count", 64'(disp_count), 5);
        chk("R9 new values at count 5", 64'(ch_on), 0);

        // R10 status capture
        defer_en = 1'b0;
        det_raw  = 4'b1111;
        pend_gs  = {6'd32, 6'd33, 6'd40, 6'd10};
        latch(1'b1, 1'b0);
        ticks(32);
        chk("R10 no early strobe", 64'(status_strobe), 0);
        ticks(1);
        chk("R10 strobe", 64'(status_strobe), 1);
        chk("R10 masked status", 64'(det_status), 64'(4'b0110));
        idle();
        chk("R10 strobe one clock", 64'(status_strobe), 0);
        chk("R10 status held", 64'(det_status), 64'(4'b0110));
        det_raw = 4'b0001;
        ticks(64);
        chk("R10 second strobe", 64'(status_strobe), 1);
        chk("R10 off channel reports 0", 64'(det_status), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule